// File: doc/BRIEF.md
# Two-Thread Issue Stage with Load/Store Unit Steering

This block is the dispatch and issue stage of an in-order core that runs two hardware threads at once. Each thread writes instructions into its own small dispatch queue through a valid/ready handshake. Every cycle the stage looks at the oldest entry of each queue and sends it to one of four execution units: two load/store units (unit 0 and unit 1) and two ALUs (units 2 and 3). Only the oldest entry of a thread may leave, so a thread whose oldest entry cannot be placed stalls as a whole.

A memory operation either goes to whichever load/store unit is free, or carries a steer code that pins it to one unit. When a load misses in the cache, the memory stage raises a miss line for its unit. The stage then marks that unit busy and sends nothing to it until the matching fill line reports that the miss has been serviced. The other unit stays open. If each thread steers its likely-missing loads to its own unit, a miss in one thread does not hold up the other thread. When both threads want the same unit in one cycle, a round-robin pointer picks the winner.

The issue outputs are registered. For each unit they give a valid bit, the issuing thread and the instruction tag.

Top module: `smt_issue_stage`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every `iss_valid` bit is 0, both `in_ready` bits are 1 and no load/store unit is busy.
- R2: Each thread's queue holds 4 entries. An entry is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low exactly while the queue holds 4 entries. Each entry stores an op (0 = ALU, 1 = load, 2 = store, 3 = handled as ALU), a 2-bit steer code and a tag.
- R3: A thread issues only the oldest entry of its queue, at most one per cycle. When that entry cannot be placed, the younger entries of the thread wait behind it.
- R4: An ALU op (op 0 or 3) goes to unit 2 or unit 3 and ignores its steer code. When both ALUs are open to it, unit 2 is chosen.
- R5: A load or store with steer 0 or 3 goes to the lowest-numbered open load/store unit. Steer 1 goes only to unit 0 and steer 2 goes only to unit 1. A pinned op waits while its unit is not available.
- R6: A load/store unit becomes busy on the edge where its `ls_miss` bit is high and stays busy until an edge where its `ls_fill` bit is high. When both bits are high on the same edge, the unit stays busy. A unit whose `ls_miss` bit is high is already closed to issue in that same cycle.
- R7: Nothing is issued to a load/store unit while that unit is busy.
- R8: At most one instruction is granted to each unit per cycle. If the first open unit of both threads is the same unit, the thread named by the round-robin pointer gets it and the other thread takes its next open unit, if it has one. The pointer starts at thread 0 and toggles after every such contested cycle.
- R9: Issue results appear on the outputs one clock after the decision. An entry accepted on edge k can issue on edge k+1 at the earliest. On a unit with `iss_valid` low, `iss_thread` and `iss_tag` read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 2 | Per-thread write request into the queue |
| in_ready | output | 2 | Per-thread queue has a free entry |
| in_op | input | 2x2 | Per-thread op class of the entry being written |
| in_steer | input | 2x2 | Per-thread steer code (0 any, 1 unit 0, 2 unit 1, 3 any) |
| in_tag | input | 2xTAG_W | Per-thread instruction tag |
| ls_miss | input | 2 | Per load/store unit: the op in that unit missed |
| ls_fill | input | 2 | Per load/store unit: the outstanding miss is serviced |
| iss_valid | output | 4 | Per unit: an instruction was issued to it |
| iss_thread | output | 4x1 | Per unit: thread that issued |
| iss_tag | output | 4xTAG_W | Per unit: tag of the issued instruction |

## Verification
A wrong busy bit shows up at the ports as a grant on a unit whose miss has not been filled, or as a pinned load that stays stuck after its fill. Both appear within one cycle of the edge that should have changed the bit. A wrong round-robin pointer or queue pointer shows on the next contested cycle as swapped thread IDs on the ALUs, or as tags that leave out of order. Because the reference model compares every unit's valid bit, thread ID and tag, and both ready bits, on every cycle, any such fault is reported in the cycle where it first reaches the outputs.

// File: rtl/smt_issue_pkg.sv
package smt_issue_pkg;
  parameter int NTHR  = 2;
  parameter int NLSU  = 2;
  parameter int NALU  = 2;
  parameter int NUNIT = NLSU + NALU;
  parameter int OP_W  = 2;
  parameter int ST_W  = 2;
  parameter int TID_W = (NTHR > 1) ? $clog2(NTHR) : 1;
  parameter int UID_W = $clog2(NUNIT);

  typedef enum logic [OP_W-1:0] {
    OP_ALU   = 2'd0,
    OP_LOAD  = 2'd1,
    OP_STORE = 2'd2,
    OP_ALT   = 2'd3
  } op_e;

  // Units this op may use: load/store units occupy the low indices.
  function automatic logic [NUNIT-1:0] unit_mask(input logic [OP_W-1:0] op,
                                                 input logic [ST_W-1:0] st);
    logic [NUNIT-1:0] m;
    m = '0;
    if (op == OP_LOAD || op == OP_STORE) begin
      if (st == 2'd1)      m[0] = 1'b1;
      else if (st == 2'd2) m[1] = 1'b1;
      else                 m[NLSU-1:0] = '1;
    end else begin
      m[NUNIT-1:NLSU] = '1;
    end
    return m;
  endfunction
endpackage

// File: rtl/dispatch_fifo.sv
module dispatch_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         head_valid,
  output logic [W-1:0] head_data,
  input  logic         pop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;
  logic          push, do_pop;

  assign in_ready   = (cnt != CW'(DEPTH));
  assign head_valid = (cnt != '0);
  assign head_data  = mem[rd_ptr];
  assign push       = in_valid & in_ready;
  assign do_pop     = pop & head_valid;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push)   wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R2
  fifo_fill_step_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !do_pop) |=> (cnt == $past(cnt) + 1'b1));

  // R2
  fifo_never_over_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt <= CW'(DEPTH)));
endmodule

// File: rtl/unit_busy_track.sv
module unit_busy_track #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] miss,
  input  logic [N-1:0] fill,
  output logic [N-1:0] busy_q
);
  always_ff @(posedge clk) begin
    if (rst) busy_q <= '0;
    else     busy_q <= (busy_q & ~fill) | miss;
  end

  // R6
  miss_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (miss != '0) |=> ((busy_q & $past(miss)) == $past(miss)));

  // R6
  fill_frees_unit_chk: assert property (@(posedge clk) disable iff (rst)
    ((fill & ~miss) != '0) |=> ((busy_q & $past(fill & ~miss)) == '0));
endmodule

// File: rtl/issue_arbiter.sv
module issue_arbiter
  import smt_issue_pkg::*;
#(
  parameter int NU = NUNIT,
  parameter int UW = UID_W
) (
  input  logic [NTHR-1:0]         req,
  input  logic [NTHR-1:0][NU-1:0] mask,
  input  logic [NU-1:0]           free,
  input  logic                    rr,
  output logic [NTHR-1:0]         grant,
  output logic [NTHR-1:0][UW-1:0] unit,
  output logic                    contested
);
  function automatic logic [UW-1:0] lowest(input logic [NU-1:0] v);
    logic [UW-1:0] r;
    r = '0;
    for (int i = NU - 1; i >= 0; i--) if (v[i]) r = UW'(i);
    return r;
  endfunction

  logic [NTHR-1:0][NU-1:0] cand;
  logic [NTHR-1:0][UW-1:0] first;
  logic [NTHR-1:0]         has;
  logic [NU-1:0]           left;
  logic                    p, o;

  always_comb begin
    for (int t = 0; t < NTHR; t++) begin
      cand[t]  = req[t] ? (mask[t] & free) : '0;
      has[t]   = |cand[t];
      first[t] = lowest(cand[t]);
    end
    p = rr;
    o = ~rr;
    grant    = '0;
    unit     = '0;
    grant[p] = has[p];
    unit[p]  = first[p];
    left     = cand[o] & ~(has[p] ? (NU'(1) << first[p]) : '0);
    grant[o] = |left;
    unit[o]  = lowest(left);
    contested = has[p] & has[o] & (first[p] == first[o]);
  end
endmodule

// File: rtl/smt_issue_stage.sv
module smt_issue_stage
  import smt_issue_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NTHR-1:0]              in_valid,
  output logic [NTHR-1:0]              in_ready,
  input  logic [NTHR-1:0][OP_W-1:0]    in_op,
  input  logic [NTHR-1:0][ST_W-1:0]    in_steer,
  input  logic [NTHR-1:0][TAG_W-1:0]   in_tag,
  input  logic [NLSU-1:0]              ls_miss,
  input  logic [NLSU-1:0]              ls_fill,
  output logic [NUNIT-1:0]             iss_valid,
  output logic [NUNIT-1:0][TID_W-1:0]  iss_thread,
  output logic [NUNIT-1:0][TAG_W-1:0]  iss_tag
);
  localparam int EW = OP_W + ST_W + TAG_W;

  logic [NTHR-1:0]            head_vld;
  logic [NTHR-1:0][EW-1:0]    head_data;
  logic [NTHR-1:0][NUNIT-1:0] head_mask;
  logic [NTHR-1:0]            gnt;
  logic [NTHR-1:0][UID_W-1:0] gnt_unit;
  logic [NLSU-1:0]            busy_q;
  logic [NUNIT-1:0]           unit_free;
  logic                       contested, rr;

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    dispatch_fifo #(.DEPTH(DEPTH), .W(EW)) u_fifo (
      .clk(clk), .rst(rst),
      .in_valid(in_valid[t]), .in_ready(in_ready[t]),
      .in_data({in_op[t], in_steer[t], in_tag[t]}),
      .head_valid(head_vld[t]), .head_data(head_data[t]),
      .pop(gnt[t])
    );
    assign head_mask[t] = unit_mask(head_data[t][EW-1 -: OP_W],
                                    head_data[t][TAG_W +: ST_W]);
  end

  unit_busy_track #(.N(NLSU)) u_busy (
    .clk(clk), .rst(rst), .miss(ls_miss), .fill(ls_fill), .busy_q(busy_q)
  );

  assign unit_free = {{NALU{1'b1}}, ~(busy_q | ls_miss)};

  issue_arbiter u_arb (
    .req(head_vld), .mask(head_mask), .free(unit_free), .rr(rr),
    .grant(gnt), .unit(gnt_unit), .contested(contested)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_valid  <= '0;
      iss_thread <= '0;
      iss_tag    <= '0;
      rr         <= 1'b0;
    end else begin
      iss_valid  <= '0;
      iss_thread <= '0;
      iss_tag    <= '0;
      for (int t = 0; t < NTHR; t++) begin
        if (gnt[t]) begin
          iss_valid[gnt_unit[t]]  <= 1'b1;
          iss_thread[gnt_unit[t]] <= TID_W'(t);
          iss_tag[gnt_unit[t]]    <= head_data[t][TAG_W-1:0];
        end
      end
      if (contested) rr <= ~rr;
    end
  end

  // Assertions
  logic [NUNIT-1:0] from_t1;
  always_comb
    for (int u = 0; u < NUNIT; u++) from_t1[u] = (iss_thread[u] != '0);

  for (genvar u = 0; u < NLSU; u++) begin : g_lsu_chk
    // R7
    no_busy_issue_chk: assert property (@(posedge clk) disable iff (rst)
      iss_valid[u] |-> !$past(busy_q[u] | ls_miss[u]));
  end

  // R3
  one_per_thread_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(iss_valid & from_t1) <= 1) && ($countones(iss_valid & ~from_t1) <= 1));

  // R8
  distinct_unit_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt == 2'b11) |-> (gnt_unit[0] != gnt_unit[1]));

  for (genvar t = 0; t < NTHR; t++) begin : g_thr_chk
    // R5
    allowed_unit_chk: assert property (@(posedge clk) disable iff (rst)
      gnt[t] |-> (head_mask[t][gnt_unit[t]] && unit_free[gnt_unit[t]]));
  end
endmodule

// File: tb/smt_issue_stage_tb.sv
module smt_issue_stage_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [1:0]       in_valid = '0;
  logic [1:0]       in_ready;
  logic [1:0][1:0]  in_op = '0;
  logic [1:0][1:0]  in_steer = '0;
  logic [1:0][7:0]  in_tag = '0;
  logic [1:0]       ls_miss = '0;
  logic [1:0]       ls_fill = '0;
  logic [3:0]       iss_valid;
  logic [3:0][0:0]  iss_thread;
  logic [3:0][7:0]  iss_tag;

  smt_issue_stage #(.TAG_W(8), .DEPTH(4)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_steer(in_steer), .in_tag(in_tag),
    .ls_miss(ls_miss), .ls_fill(ls_fill),
    .iss_valid(iss_valid), .iss_thread(iss_thread), .iss_tag(iss_tag)
  );

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;
  string cur_req = "R1";

  // Reference model state
  bit [11:0] mq0[$], mq1[$];
  bit [1:0]  mbusy = '0;
  bit        mrr = 0;
  bit [3:0]  ev = '0;
  bit [3:0]  et = '0;
  bit [7:0]  eg[4] = '{default: 8'h0};

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int qsize(input int t);
    return (t == 0) ? mq0.size() : mq1.size();
  endfunction

  function automatic bit [11:0] qhead(input int t);
    return (t == 0) ? mq0[0] : mq1[0];
  endfunction

  function automatic int low_bit(input bit [3:0] v);
    int r = -1;
    for (int i = 3; i >= 0; i--) if (v[i]) r = i;
    return r;
  endfunction

  // One clock: compare last edge's results, drive inputs, advance the model.
  task automatic cyc(input bit v0, input bit [1:0] op0, input bit [1:0] st0, input bit [7:0] tg0,
                     input bit v1, input bit [1:0] op1, input bit [1:0] st1, input bit [7:0] tg1,
                     input bit [1:0] miss, input bit [1:0] fill);
    bit [3:0] freev, mask[2], cand[2], left;
    int first[2], p, o, sec;
    bit [1:0] rdy;
    @(negedge clk);
    if (!rst) begin
      for (int u = 0; u < 4; u++) begin
        chk(iss_valid[u] == ev[u], cur_req, $sformatf("unit%0d valid", u), iss_valid[u], ev[u]);
        chk(iss_thread[u] == et[u], cur_req, $sformatf("unit%0d thread", u), iss_thread[u], et[u]);
        chk(iss_tag[u] == eg[u], cur_req, $sformatf("unit%0d tag", u), iss_tag[u], eg[u]);
      end
      rdy = {qsize(1) < 4, qsize(0) < 4};
      chk(in_ready == rdy, "R2", "in_ready", in_ready, rdy);
    end
    in_valid = {v1, v0};
    in_op[0] = op0; in_steer[0] = st0; in_tag[0] = tg0;
    in_op[1] = op1; in_steer[1] = st1; in_tag[1] = tg1;
    ls_miss = miss; ls_fill = fill;
    if (rst) begin
      mq0.delete(); mq1.delete(); mbusy = '0; mrr = 0;
      ev = '0; et = '0; eg = '{default: 8'h0};
      return;
    end
    freev = {2'b11, ~mbusy[1] & ~miss[1], ~mbusy[0] & ~miss[0]};
    for (int t = 0; t < 2; t++) begin
      mask[t] = '0;
      if (qsize(t) > 0) begin
        bit [11:0] e = qhead(t);
        if (e[11:10] == 2'd1 || e[11:10] == 2'd2)
          mask[t] = (e[9:8] == 2'd1) ? 4'b0001 : (e[9:8] == 2'd2) ? 4'b0010 : 4'b0011;
        else
          mask[t] = 4'b1100;
      end
      cand[t] = mask[t] & freev;
      first[t] = low_bit(cand[t]);
    end
    ev = '0; et = '0; eg = '{default: 8'h0};
    p = mrr; o = 1 - p;
    left = cand[o];
    if (first[p] >= 0) begin
      ev[first[p]] = 1; et[first[p]] = p[0]; eg[first[p]] = qhead(p)[7:0];
      left[first[p]] = 1'b0;
    end
    sec = low_bit(left);
    if (sec >= 0) begin
      ev[sec] = 1; et[sec] = o[0]; eg[sec] = qhead(o)[7:0];
    end
    if (first[p] >= 0 && first[o] >= 0 && first[p] == first[o]) mrr = ~mrr;
    if (first[p] >= 0) begin if (p == 0) void'(mq0.pop_front()); else void'(mq1.pop_front()); end
    if (sec >= 0)      begin if (o == 0) void'(mq0.pop_front()); else void'(mq1.pop_front()); end
    if (v0 && rdy[0]) mq0.push_back({op0, st0, tg0});
    if (v1 && rdy[1]) mq1.push_back({op1, st1, tg1});
    mbusy = (mbusy & ~fill) | miss;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 2'b00, 2'b00);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R1: reset state, while reset is asserted
    @(negedge clk);
    chk(iss_valid == 4'b0, "R1", "iss_valid in reset", iss_valid, 0);
    chk(in_ready == 2'b11, "R1", "in_ready in reset", in_ready, 3);
    rst = 1'b0;
    cur_req = "R1";
    idle(2);

    // R4 R8 R9: both threads stream ALU ops, contested every cycle
    cur_req = "R4/R8/R9";
    cyc(1, 0, 2, 8'h10, 1, 3, 1, 8'h20, 2'b00, 2'b00);
    cyc(1, 0, 1, 8'h11, 1, 0, 0, 8'h21, 2'b00, 2'b00);
    cyc(1, 3, 0, 8'h12, 0, 0, 0, 8'h00, 2'b00, 2'b00);
    idle(3);

    // R5: pinned loads per thread, then a contest for load/store unit 0
    cur_req = "R5/R8";
    cyc(1, 1, 1, 8'h30, 1, 1, 2, 8'h40, 2'b00, 2'b00);
    cyc(1, 1, 1, 8'h31, 1, 2, 2, 8'h41, 2'b00, 2'b00);
    cyc(1, 2, 0, 8'h32, 1, 1, 3, 8'h42, 2'b00, 2'b00);
    cyc(1, 1, 2, 8'h33, 1, 1, 2, 8'h43, 2'b00, 2'b00);
    idle(3);

    // R6 R7 R3: miss on unit 0; pinned thread 0 stalls with its ALU op behind it
    cur_req = "R6/R7/R3";
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 2'b01, 2'b00);
    cyc(1, 1, 1, 8'h50, 1, 1, 0, 8'h60, 2'b00, 2'b00);
    cyc(1, 0, 0, 8'h51, 1, 2, 0, 8'h61, 2'b00, 2'b00);
    cyc(0, 0, 0, 0, 1, 0, 0, 8'h62, 2'b00, 2'b00);
    idle(3);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 2'b00, 2'b01);
    idle(3);

    // R2: fill thread 0 while its pinned unit is busy
    cur_req = "R2/R7";
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 2'b01, 2'b00);
    for (int i = 0; i < 6; i++) cyc(1, 1, 1, 8'h70 + 8'(i), 0, 0, 0, 0, 2'b00, 2'b00);
    chk(in_ready[0] == 1'b0, "R2", "queue full ready", in_ready[0], 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 2'b00, 2'b01);
    idle(6);

    // R6: miss and fill together keep unit 1 busy; miss blocks in the same cycle
    cur_req = "R6/R7";
    cyc(0, 0, 0, 0, 1, 1, 2, 8'h90, 2'b00, 2'b00);
    cyc(0, 0, 0, 0, 1, 1, 2, 8'h91, 2'b10, 2'b00);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 2'b10, 2'b10);
    idle(2);
    cyc(1, 1, 0, 8'hA0, 0, 0, 0, 0, 2'b00, 2'b10);
    idle(4);

    // R8 R4: contested ALU cycle with one ALU-only thread and a mixed thread
    cur_req = "R8/R4";
    cyc(1, 0, 0, 8'hB0, 1, 0, 0, 8'hC0, 2'b00, 2'b00);
    cyc(1, 1, 0, 8'hB1, 1, 0, 0, 8'hC1, 2'b00, 2'b00);
    idle(4);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule